// File: doc/BRIEF.md
# Segment-Steered MMU Enable and Trap Unit

This unit sits between a segmented processor and three memory management units: one for instruction fetches, one for data and one for stack. For each memory reference it looks at the processor status code, whether the processor is in system or normal mode, the 7-bit segment number and the 16-bit address offset. It then enables exactly one of the three units, or it raises a segment trap and enables none of them.

The choice between the data unit and the stack unit is made by comparing the offset with one of two base registers, one for system segments and one for normal segments. A configuration flag says whether user programs are segmented. When the flag is set, normal-mode references are split between data and stack by the upper half of the segment space instead, and a different set of segments traps. The configuration flag and the two base registers are loaded through a small synchronous write port.

References arrive on a valid strobe. The unit has no ready signal and never applies back-pressure: it accepts one reference on every cycle in which `ref_valid` is high. Each accepted reference produces a registered result one cycle later, and that result lasts for exactly one cycle.

Top module: `seg_mmu_steer`

## Requirements
- R1: After reset all four outputs are low and the configuration flag and both base registers are zero.
- R2: A write with `wr_en` high updates the register selected by `wr_addr` at the clock edge: address 0 loads the segmented-user flag from `wr_data` bit 2, address 1 loads the system base, address 2 loads the normal base, and address 3 changes nothing. A reference in the same cycle as a write uses the old values.
- R3: The outputs respond one cycle after a reference is accepted and stay up for one cycle only. In a cycle that follows one with `ref_valid` low, all outputs are low.
- R4: A status code whose upper two bits are 11 (an instruction-space access) enables the code unit, unless the reference traps.
- R5: With the flag at 0, a reference that does not fetch instructions and does not trap compares the offset with the system base for segments 0 and 1, and with the normal base for every other segment. If the unsigned subtraction offset minus base borrows, the data unit is enabled. Otherwise the stack unit is enabled.
- R6: With the flag at 0, a normal-mode reference to segment 0 or to any segment from 64 to 127 raises the trap.
- R7: With the flag at 1, system-mode references choose between data and stack using the same base comparison as R5.
- R8: With the flag at 1, a normal-mode reference that does not fetch instructions enables the data unit for segments 2 to 63 and the stack unit for segments 66 to 127.
- R9: With the flag at 1, a normal-mode reference to segment 0, 1, 64 or 65 raises the trap. This applies to instruction fetches as well.
- R10: In every cycle at most one of the three enables and the trap output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 flag, 1 system base, 2 normal base |
| wr_data | input | 16 | Write data |
| ref_valid | input | 1 | Memory reference strobe |
| ref_status | input | 4 | Processor status code |
| ref_sys | input | 1 | 1 = system mode, 0 = normal mode |
| ref_seg | input | 7 | Segment number |
| ref_off | input | 16 | Address offset |
| en_code | output | 1 | Instruction unit enable |
| en_data | output | 1 | Data unit enable |
| en_stack | output | 1 | Stack unit enable |
| seg_trap | output | 1 | Segment trap violation |

## Verification
The assertions check on every cycle that the enables and the trap are mutually exclusive, that an idle cycle leaves all outputs low, and that an instruction fetch, a trapping normal-mode segment or a segmented upper-half reference produces its output one cycle later. Only the bench scenarios show the full decision table. It sweeps every segment in both modes and with both flag values, and uses offsets on either side of each base value to exercise the borrow boundary. It also checks that writes go to the right register and that a write to the unused address has no effect.

// File: rtl/seg_mmu_pkg.sv
package seg_mmu_pkg;
  localparam int SEG_W  = 7;
  localparam int OFF_W  = 16;
  localparam int STAT_W = 4;
  localparam int ADDR_W = 2;
  localparam int FLAG_BIT = 2;

  localparam logic [STAT_W-1:0] CODE_MASK  = 4'b1100;
  localparam logic [STAT_W-1:0] CODE_MATCH = 4'b1100;

  localparam logic [ADDR_W-1:0] A_FLAG = 2'd0;
  localparam logic [ADDR_W-1:0] A_SYSB = 2'd1;
  localparam logic [ADDR_W-1:0] A_NRMB = 2'd2;

  typedef struct packed {
    logic code;
    logic data;
    logic stack;
    logic trap;
  } sel_t;
endpackage

// File: rtl/seg_mmu_regs.sv
module seg_mmu_regs
  import seg_mmu_pkg::*;
#(
  parameter int W = OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              seg_user,
  output logic [W-1:0]      sys_base,
  output logic [W-1:0]      nrm_base
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_user <= 1'b0;
      sys_base <= '0;
      nrm_base <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_FLAG:  seg_user <= wr_data[FLAG_BIT];
        A_SYSB:  sys_base <= wr_data;
        A_NRMB:  nrm_base <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seg_mmu_decode.sv
module seg_mmu_decode
  import seg_mmu_pkg::*;
#(
  parameter int SW = SEG_W,
  parameter int OW = OFF_W
) (
  input  logic [STAT_W-1:0] status,
  input  logic              sys,
  input  logic [SW-1:0]     seg,
  input  logic [OW-1:0]     off,
  input  logic              seg_user,
  input  logic [OW-1:0]     sys_base,
  input  logic [OW-1:0]     nrm_base,
  output sel_t              sel
);
  localparam int HALF = SW - 1;

  logic          low_seg;
  logic          upper;
  logic          trap;
  logic          is_code;
  logic          borrow;
  logic [OW-1:0] base;
  logic [OW:0]   diff;

  assign low_seg = (seg[HALF-1:1] == '0) && !upper;
  assign upper   = seg[HALF];

  always_comb begin
    if (sys)           trap = 1'b0;
    else if (seg_user) trap = (seg[HALF-1:1] == '0);
    else               trap = (seg == '0) || upper;
  end

  assign is_code = ((status & CODE_MASK) == CODE_MATCH);
  assign base    = low_seg ? sys_base : nrm_base;
  assign diff    = {1'b0, off} - {1'b0, base};
  assign borrow  = diff[OW];

  always_comb begin
    sel = '0;
    if (trap) begin
      sel.trap = 1'b1;
    end else if (is_code) begin
      sel.code = 1'b1;
    end else if (seg_user && !sys) begin
      sel.data  = !upper;
      sel.stack = upper;
    end else begin
      sel.data  = borrow;
      sel.stack = !borrow;
    end
  end
endmodule

// File: rtl/seg_mmu_steer.sv
module seg_mmu_steer
  import seg_mmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [OFF_W-1:0]  wr_data,
  input  logic              ref_valid,
  input  logic [STAT_W-1:0] ref_status,
  input  logic              ref_sys,
  input  logic [SEG_W-1:0]  ref_seg,
  input  logic [OFF_W-1:0]  ref_off,
  output logic              en_code,
  output logic              en_data,
  output logic              en_stack,
  output logic              seg_trap
);
  logic              seg_user;
  logic [OFF_W-1:0]  sys_base;
  logic [OFF_W-1:0]  nrm_base;
  sel_t              next_sel;
  sel_t              out_q;

  seg_mmu_regs #(.W(OFF_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .seg_user (seg_user),
    .sys_base (sys_base),
    .nrm_base (nrm_base)
  );

  seg_mmu_decode #(.SW(SEG_W), .OW(OFF_W)) u_dec (
    .status   (ref_status),
    .sys      (ref_sys),
    .seg      (ref_seg),
    .off      (ref_off),
    .seg_user (seg_user),
    .sys_base (sys_base),
    .nrm_base (nrm_base),
    .sel      (next_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         out_q <= '0;
    else if (ref_valid) out_q <= next_sel;
    else                out_q <= '0;
  end

  assign en_code  = out_q.code;
  assign en_data  = out_q.data;
  assign en_stack = out_q.stack;
  assign seg_trap = out_q.trap;
endmodule

// File: rtl/seg_mmu_steer_chk.sv
module seg_mmu_steer_chk
  import seg_mmu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ref_valid,
  input logic [STAT_W-1:0] ref_status,
  input logic              ref_sys,
  input logic [SEG_W-1:0]  ref_seg,
  input logic              seg_user,
  input logic              en_code,
  input logic              en_data,
  input logic              en_stack,
  input logic              seg_trap
);
  logic is_code;
  assign is_code = (ref_status[3:2] == 2'b11);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_code, en_data, en_stack, seg_trap}));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> !(en_code || en_data || en_stack || seg_trap));

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> $countones({en_code, en_data, en_stack, seg_trap}) == 1);

  a_r4_code_sys: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_sys && is_code) |=> en_code);

  a_r6_trap_seg0: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_sys && ref_seg == 7'd0) |=> seg_trap);

  a_r9_trap_low_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_sys && seg_user && ref_seg[5:1] == 5'd0) |=> seg_trap);

  a_r8_upper_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_sys && seg_user && !is_code && ref_seg >= 7'd66) |=> en_stack);
endmodule

bind seg_mmu_steer seg_mmu_steer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_valid  (ref_valid),
  .ref_status (ref_status),
  .ref_sys    (ref_sys),
  .ref_seg    (ref_seg),
  .seg_user   (seg_user),
  .en_code    (en_code),
  .en_data    (en_data),
  .en_stack   (en_stack),
  .seg_trap   (seg_trap)
);

// File: tb/tb_seg_mmu_steer.sv
`timescale 1ns/1ps
module tb_seg_mmu_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ref_valid = 1'b0;
  logic [3:0]  ref_status = '0;
  logic        ref_sys = 1'b0;
  logic [6:0]  ref_seg = '0;
  logic [15:0] ref_off = '0;
  logic        en_code, en_data, en_stack, seg_trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  seg_mmu_steer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ref_valid(ref_valid), .ref_status(ref_status), .ref_sys(ref_sys),
    .ref_seg(ref_seg), .ref_off(ref_off),
    .en_code(en_code), .en_data(en_data), .en_stack(en_stack), .seg_trap(seg_trap)
  );

  // {code,data,stack,trap}
  function automatic logic [3:0] model(input bit fl, input logic [15:0] sb, input logic [15:0] nb,
                                       input logic [3:0] st, input bit sys,
                                       input int seg, input logic [15:0] off);
    bit trap;
    logic [15:0] base;
    if (sys) trap = 0;
    else if (fl) trap = (seg == 0 || seg == 1 || seg == 64 || seg == 65);
    else trap = (seg == 0 || seg >= 64);
    if (trap) return 4'b0001;
    if (st[3:2] == 2'b11) return 4'b1000;
    if (fl && !sys) return (seg < 64) ? 4'b0100 : 4'b0010;
    base = (seg < 2) ? sb : nb;
    return (int'(off) - int'(base) < 0) ? 4'b0100 : 4'b0010;
  endfunction

  function automatic string tag_of(input bit fl, input bit sys, input int seg, input logic [3:0] e);
    if (e[0]) return fl ? "R9" : "R6";
    if (e[3]) return "R4";
    if (fl && !sys) return "R8";
    return fl ? "R7" : "R5";
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {en_code, en_data, en_stack, seg_trap};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: outputs got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic one_ref(input string tag, input logic [3:0] st, input bit sys,
                         input int seg, input logic [15:0] off, input logic [3:0] exp);
    ref_valid = 1'b1; ref_status = st; ref_sys = sys; ref_seg = 7'(seg); ref_off = off;
    @(negedge clk);
    ref_valid = 1'b0;
    check(tag, exp);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] offs [6];
    logic [15:0] sb, nb;
    offs = '{16'h0000, 16'h1233, 16'h1234, 16'h7FFF, 16'h8000, 16'hFFFF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 4'b0000);
    // R1: zero bases, offset 0 -> no borrow -> stack
    one_ref("R1", 4'b0000, 1'b1, 5, 16'h0000, 4'b0010);
    @(negedge clk);
    check("R3", 4'b0000);

    sb = 16'h8000; nb = 16'h1234;
    wr(2'd1, sb);
    wr(2'd2, nb);
    wr(2'd3, 16'hFFFF);  // R2: address 3 has no effect
    one_ref("R2", 4'b0000, 1'b1, 1, 16'h7FFF, 4'b0100);
    one_ref("R2", 4'b0000, 1'b1, 1, 16'h8000, 4'b0010);
    one_ref("R2", 4'b0000, 1'b1, 9, 16'h1233, 4'b0100);
    one_ref("R2", 4'b0000, 1'b0, 9, 16'h1234, 4'b0010);
    // R2: only bit 2 of the flag write counts
    wr(2'd0, 16'hFFFB);
    one_ref("R2", 4'b0000, 1'b0, 70, 16'h0000, 4'b0001);

    for (int fl = 0; fl < 2; fl++) begin
      wr(2'd0, fl ? 16'h0004 : 16'h0000);
      for (int sys = 0; sys < 2; sys++)
        for (int seg = 0; seg < 128; seg++)
          for (int c = 0; c < 2; c++)
            for (int k = 0; k < 6; k++) begin
              logic [3:0] st, e;
              st = c ? 4'b1101 : 4'b1001;
              e = model(fl[0], sb, nb, st, sys[0], seg, offs[k]);
              one_ref(tag_of(fl[0], sys[0], seg, e), st, sys[0], seg, offs[k], e);
            end
    end

    // R3: back-to-back then idle
    ref_valid = 1'b1; ref_status = 4'b1100; ref_sys = 1'b1; ref_seg = 7'd3;
    @(negedge clk);
    check("R3", 4'b1000);
    ref_seg = 7'd0; ref_sys = 1'b0;
    @(negedge clk);
    ref_valid = 1'b0;
    check("R3", 4'b0001);
    @(negedge clk);
    check("R3", 4'b0000);

    // R2: write in the same cycle as a reference uses the old base
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h0000;
    ref_valid = 1'b1; ref_status = 4'b0000; ref_sys = 1'b1; ref_seg = 7'd0; ref_off = 16'h0010;
    @(negedge clk);
    wr_en = 1'b0; ref_valid = 1'b0;
    check("R2", 4'b0100);
    one_ref("R2", 4'b0000, 1'b1, 0, 16'h0010, 4'b0010);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule